// File: doc/BRIEF.md
# Serial Port DMA Request Generator

This block sits beside the receive and transmit FIFOs of a serial port and tells a DMA controller when data can move. Each direction has two request lines. A single request asks for one transfer. A burst request asks for a block of transfers once the FIFO has passed a programmable occupancy threshold. Each direction has its own DMA enable bit. When the stop-on-error option is on, a receive error shuts off all receive requests until software clears the error interrupt.

When the DMA controller finishes a channel it sends a completion pulse. The block latches that event per channel and merges it onto the port's interrupt line, alongside the port's other interrupt sources. Software clears each completion flag with a write-one strobe. The FIFO occupancy counts and the thresholds come from the surrounding port logic.

Every request output is registered, so it reflects the inputs sampled on the previous rising clock edge. The reset is asynchronous and active-low. Its release is synchronised inside the block.

Top module: `dma_req_gen`

## Requirements
- R1: `rx_sreq` is 1 when `rx_count` is nonzero and receive DMA is enabled and not locked out; otherwise it is 0.
- R2: `rx_breq` is 1 when `rx_count >= rx_level` and receive DMA is enabled and not locked out.
- R3: `tx_sreq` is 1 when `tx_count` is less than the FIFO depth (at least one free slot) and `tx_dma_en` is 1.
- R4: `tx_breq` is 1 when `tx_count < tx_level` and `tx_dma_en` is 1.
- R5: With `rx_dma_en` at 0 both receive requests are 0. With `tx_dma_en` at 0 both transmit requests are 0. Each enable has no effect on the other direction.
- R6: A cycle with `halt_on_err` and `rx_err` both at 1 sets a lockout. The lockout forces both receive requests to 0 from the next output update on. It stays set until a cycle with `err_clr` at 1 and no new error in that cycle; if both come in the same cycle, the error wins.
- R7: When `halt_on_err` is 0, a pulse on `rx_err` changes no request output.
- R8: A pulse on `rx_done` sets `done_stat[0]` and a pulse on `tx_done` sets `done_stat[1]`. Each bit is cleared by a cycle with the matching bit of `done_clr` at 1. If set and clear come in the same cycle, set wins.
- R9: `irq` is `port_irq` OR-ed with any set bit of `done_stat`.
- R10: All requests and `done_stat` are registered: they reflect the inputs sampled on the previous rising clock edge. They are 0 while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_count | input | CW | Receive FIFO occupancy |
| tx_count | input | CW | Transmit FIFO occupancy |
| rx_level | input | CW | Receive burst threshold |
| tx_level | input | CW | Transmit burst threshold |
| rx_dma_en | input | 1 | Receive DMA enable |
| tx_dma_en | input | 1 | Transmit DMA enable |
| halt_on_err | input | 1 | Stop receive DMA on a receive error |
| rx_err | input | 1 | Receive error pulse |
| err_clr | input | 1 | Error interrupt clear strobe |
| rx_done | input | 1 | Receive DMA completion pulse |
| tx_done | input | 1 | Transmit DMA completion pulse |
| done_clr | input | 2 | Write-one clear of completion flags (bit0 rx, bit1 tx) |
| port_irq | input | 1 | The port's other interrupt sources |
| rx_sreq | output | 1 | Receive single request |
| rx_breq | output | 1 | Receive burst request |
| tx_sreq | output | 1 | Transmit single request |
| tx_breq | output | 1 | Transmit burst request |
| done_stat | output | 2 | Latched completion flags (bit0 rx, bit1 tx) |
| irq | output | 1 | Merged port interrupt |

## Verification
The assertions assume that the occupancy counts never exceed the FIFO depth (CW is wide enough to hold DEPTH). They also assume the pulse inputs are synchronous and last exactly one cycle. The stimulus changes every input on the falling edge and returns each pulse to 0 after one rising edge. The counts it drives range only from 0 to DEPTH, and the thresholds it drives stay within the same range.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;
  localparam int CH_RX = 0;
  localparam int CH_TX = 1;
  localparam int NUM_CH = 2;

  typedef struct packed {
    logic single;
    logic burst;
  } req_pair_t;
endpackage

// File: rtl/dma_rst_sync.sv
module dma_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/dma_err_lock.sv
module dma_err_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_en,
  input  logic err_pulse,
  input  logic clr,
  output logic lock_d,
  output logic lock_q
);
  logic set_c;

  always_comb begin
    set_c  = halt_en & err_pulse;
    lock_d = lock_q;
    if (clr)   lock_d = 1'b0;
    if (set_c) lock_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b0;
    else        lock_q <= lock_d;
  end

  // R6
  lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_en && err_pulse) |=> lock_q);

  // R6
  lock_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && clr && !(halt_en && err_pulse)) |=> !lock_q);
endmodule

// File: rtl/dma_rx_req.sv
module dma_rx_req #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] level,
  input  logic          en,
  input  logic          block,
  output dma_req_pkg::req_pair_t req_q
);
  import dma_req_pkg::*;

  req_pair_t req_d;
  logic      pass_c;

  always_comb begin
    pass_c       = en & ~block;
    req_d.single = pass_c & (count != '0);
    req_d.burst  = pass_c & (count >= level);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_d;
  end

  // R6
  rx_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    block |=> (!req_q.single && !req_q.burst));

  // R1
  rx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !block && count != '0) |=> req_q.single);

  // R2
  rx_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count < level) |=> !req_q.burst);
endmodule

// File: rtl/dma_tx_req.sv
module dma_tx_req #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] level,
  input  logic          en,
  output dma_req_pkg::req_pair_t req_q
);
  import dma_req_pkg::*;

  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  req_pair_t req_d;

  always_comb begin
    req_d.single = en & (count < FULL);
    req_d.burst  = en & (count < level);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_d;
  end

  // R3
  tx_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count >= FULL) |=> !req_q.single);

  // R5
  tx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!req_q.single && !req_q.burst));
endmodule

// File: rtl/dma_done_latch.sv
module dma_done_latch #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set_i,
  input  logic [NCH-1:0] clr_i,
  output logic [NCH-1:0] stat_q
);
  logic [NCH-1:0] stat_d;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_comb begin
      stat_d[i] = stat_q[i];
      if (clr_i[i]) stat_d[i] = 1'b0;
      if (set_i[i]) stat_d[i] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q[i] <= 1'b0;
      else        stat_q[i] <= stat_d[i];
    end

    // R8
    done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> stat_q[i]);

    // R8
    done_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !stat_q[i]);
  end
endmodule

// File: rtl/dma_req_gen.sv
module dma_req_gen #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] tx_count,
  input  logic [CW-1:0] rx_level,
  input  logic [CW-1:0] tx_level,
  input  logic          rx_dma_en,
  input  logic          tx_dma_en,
  input  logic          halt_on_err,
  input  logic          rx_err,
  input  logic          err_clr,
  input  logic          rx_done,
  input  logic          tx_done,
  input  logic [1:0]    done_clr,
  input  logic          port_irq,
  output logic          rx_sreq,
  output logic          rx_breq,
  output logic          tx_sreq,
  output logic          tx_breq,
  output logic [1:0]    done_stat,
  output logic          irq
);
  import dma_req_pkg::*;

  logic      srst_n;
  logic      lock_d;
  logic      lock_q;
  req_pair_t rx_q;
  req_pair_t tx_q;
  logic [NUM_CH-1:0] done_set;

  dma_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  dma_err_lock u_lock (
    .clk       (clk),
    .rst_n     (srst_n),
    .halt_en   (halt_on_err),
    .err_pulse (rx_err),
    .clr       (err_clr),
    .lock_d    (lock_d),
    .lock_q    (lock_q)
  );

  dma_rx_req #(.CW(CW)) u_rx (
    .clk   (clk),
    .rst_n (srst_n),
    .count (rx_count),
    .level (rx_level),
    .en    (rx_dma_en),
    .block (lock_d),
    .req_q (rx_q)
  );

  dma_tx_req #(.DEPTH(DEPTH), .CW(CW)) u_tx (
    .clk   (clk),
    .rst_n (srst_n),
    .count (tx_count),
    .level (tx_level),
    .en    (tx_dma_en),
    .req_q (tx_q)
  );

  always_comb begin
    done_set         = '0;
    done_set[CH_RX]  = rx_done;
    done_set[CH_TX]  = tx_done;
  end

  dma_done_latch #(.NCH(NUM_CH)) u_done (
    .clk    (clk),
    .rst_n  (srst_n),
    .set_i  (done_set),
    .clr_i  (done_clr),
    .stat_q (done_stat)
  );

  assign rx_sreq = rx_q.single;
  assign rx_breq = rx_q.burst;
  assign tx_sreq = tx_q.single;
  assign tx_breq = tx_q.burst;
  assign irq     = port_irq | (|done_stat);

  // R9
  irq_merge_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (done_stat != 2'b00) |-> irq);

  // R6
  lock_quiet_chk: assert property (@(posedge clk) disable iff (!srst_n)
    lock_q |-> (!rx_sreq && !rx_breq));
endmodule

// File: tb/dma_req_gen_tb.sv
`timescale 1ns/100ps
module dma_req_gen_tb;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic [CW-1:0] rx_count, tx_count, rx_level, tx_level;
  logic rx_dma_en, tx_dma_en, halt_on_err, rx_err, err_clr;
  logic rx_done, tx_done, port_irq;
  logic [1:0] done_clr;
  logic rx_sreq, rx_breq, tx_sreq, tx_breq, irq;
  logic [1:0] done_stat;

  int checks = 0;
  int fails  = 0;
  logic [6:0] exp_q[$];
  string      tag_q[$];
  logic       m_lock;
  logic [1:0] m_done;

  always #2.5 clk = ~clk;

  dma_req_gen #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .rx_count(rx_count), .tx_count(tx_count),
    .rx_level(rx_level), .tx_level(tx_level),
    .rx_dma_en(rx_dma_en), .tx_dma_en(tx_dma_en),
    .halt_on_err(halt_on_err), .rx_err(rx_err), .err_clr(err_clr),
    .rx_done(rx_done), .tx_done(tx_done), .done_clr(done_clr),
    .port_irq(port_irq),
    .rx_sreq(rx_sreq), .rx_breq(rx_breq),
    .tx_sreq(tx_sreq), .tx_breq(tx_breq),
    .done_stat(done_stat), .irq(irq)
  );

  function automatic logic [6:0] outs();
    return {rx_sreq, rx_breq, tx_sreq, tx_breq, done_stat, irq};
  endfunction

  task automatic check(input logic [6:0] act, input logic [6:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // driver: model the expected result of the coming edge, push it, advance one cycle
  task automatic go(input string tag);
    logic rs, rb, ts, tb;
    m_lock = (halt_on_err & rx_err) | (m_lock & ~err_clr);
    m_done = {tx_done, rx_done} | (m_done & ~done_clr);
    rs = rx_dma_en & ~m_lock & (rx_count != 0);
    rb = rx_dma_en & ~m_lock & (rx_count >= rx_level);
    ts = tx_dma_en & (tx_count < DEPTH);
    tb = tx_dma_en & (tx_count < tx_level);
    exp_q.push_back({rs, rb, ts, tb, m_done, port_irq | (|m_done)});
    tag_q.push_back(tag);
    @(posedge clk);
    @(negedge clk);
    rx_err = 0; err_clr = 0; rx_done = 0; tx_done = 0; done_clr = 2'b00;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() != 0) check(outs(), exp_q.pop_front(), tag_q.pop_front());
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; m_lock = 0; m_done = 0;
    rx_count = 0; tx_count = 0; rx_level = 4; tx_level = 4;
    rx_dma_en = 1; tx_dma_en = 1; halt_on_err = 0;
    rx_err = 0; err_clr = 0; rx_done = 0; tx_done = 0; done_clr = 0; port_irq = 0;
    repeat (4) @(posedge clk);
    #1 check(outs(), 7'b0, "R10 reset state");
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 / R2 receive thresholds
    rx_count = 0;  go("R1 empty rx");
    rx_count = 1;  go("R1 one entry");
    rx_count = 3;  go("R2 below level");
    rx_count = 4;  go("R2 at level");
    rx_count = 9;  go("R2 above level");
    // R3 / R4 transmit thresholds
    tx_count = 3;  go("R4 below level");
    tx_count = 4;  go("R4 at level");
    tx_count = DEPTH - 1; go("R3 one free slot");
    tx_count = DEPTH;     go("R3 full");
    // R5 enables independent
    rx_dma_en = 0; tx_count = 0; go("R5 rx disabled");
    rx_dma_en = 1; tx_dma_en = 0; go("R5 tx disabled");
    tx_dma_en = 1; go("R5 both enabled");
    // R7 error ignored without halt
    rx_count = 5; rx_err = 1; go("R7 error no halt");
    go("R7 after error");
    // R6 lockout
    halt_on_err = 1; rx_err = 1; go("R6 lock set");
    go("R6 lock held");
    rx_err = 1; err_clr = 1; go("R6 error beats clear");
    err_clr = 1; go("R6 lock cleared");
    go("R6 after clear");
    // R8 / R9 completion
    rx_done = 1; go("R8 rx done set");
    tx_done = 1; done_clr = 2'b01; go("R8 rx clr tx set");
    tx_done = 1; done_clr = 2'b10; go("R8 set beats clear");
    done_clr = 2'b10; go("R8 tx clr");
    port_irq = 1; go("R9 port irq passes");
    port_irq = 0; go("R9 irq low");
    // R10 registered timing with a changing pattern
    for (int i = 0; i <= DEPTH; i++) begin
      rx_count = CW'(i); tx_count = CW'(DEPTH - i); rx_level = CW'(i % 7); tx_level = CW'(i % 5);
      go("R10 sweep");
    end
    @(posedge clk); #2;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule